// File: doc/BRIEF.md
# ECC Error Diagnostic Logger

This block sits beside a 64-bit single-error-correct, double-error-detect decoder and keeps a diagnostic record of what the decoder reports. On every access the decoder presents the data word, the 8 check bits read from memory, the 8-bit syndrome, and two flags: one for a correctable error and one for an uncorrectable error. The logger counts flagged accesses in a small counter that stops at its maximum. It keeps the data word and syndrome of the first fault, holds the check bits of the most recent access, and sets a sticky flag once any uncorrectable error is seen.

Software reads the record through a four-word, 32-bit read port with one cycle of latency. A synchronous clear input restarts logging: it empties the counter, the fault capture and the sticky flag. The check-bit register is left untouched by the clear, because it describes the latest access and not an error history.

Top module: `ecc_diag_logger`

## Requirements
- R1: An access with `acc_valid` high and either `acc_sbe` or `acc_mbe` high (or both) adds exactly one to the error count. Accesses with `acc_valid` low, or with both flags low, leave the count unchanged.
- R2: The error count is 4 bits wide and saturates at 15. Further errors keep it at 15 instead of wrapping to 0.
- R3: The first error after reset or after a clear stores that access's 64-bit data word and 8-bit syndrome, and sets the capture-valid flag.
- R4: While capture-valid is set, later errors do not change the stored data word or syndrome.
- R5: An access with `acc_valid` and `acc_mbe` high sets the sticky uncorrectable flag, and it stays set until a clear.
- R6: `clr` high sets the count to 0 and clears capture-valid, the stored word, the stored syndrome and the sticky flag on the next edge. When an error arrives in the same cycle as `clr`, the clear wins and the error is not logged.
- R7: Every access with `acc_valid` high loads `acc_chk` into the check-bit register, including during a clear. The clear never changes this register.
- R8: `rd_en` high loads `rd_data` at the next clock edge from the word chosen by `rd_addr`, and `rd_data` holds its value while `rd_en` is low. Address 0 holds the count in bits 3:0, the sticky uncorrectable flag in bit 4 and capture-valid in bit 5. Address 1 holds the stored syndrome in bits 7:0 and the check-bit register in bits 15:8. Address 2 holds stored data bits 31:0 and address 3 holds data bits 63:32. All other bits read as 0.
- R9: After synchronous reset, every logged value and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the count, the capture and the sticky flag |
| acc_valid | input | 1 | Decoder presents an access this cycle |
| acc_sbe | input | 1 | Access had a correctable error |
| acc_mbe | input | 1 | Access had an uncorrectable error |
| acc_data | input | 64 | Data word of the access |
| acc_chk | input | 8 | Check bits read with the access |
| acc_syn | input | 8 | Syndrome of the access |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Registered read data |

## Verification
A clear and a decoder error can arrive in the same cycle. So can a clear and a clean access that carries new check bits. The bench drives `clr` and `acc_valid` with error flags on the same falling edge, both on an empty log and on a full one. It then reads all four words. The expected result is a zero count, no capture and no sticky flag, while the check-bit field shows the check bits of that same access. A following error must then be captured as the new first fault.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int LOG_DATA_W = 64;
    localparam int LOG_CODE_W = 8;
    localparam int LOG_CNT_W  = 4;
    localparam int LOG_RD_W   = 32;

    // Fixed word slots ahead of the data slices in the read map
    typedef enum logic [1:0] {
        SLOT_STATUS = 2'd0,
        SLOT_CODES  = 2'd1,
        SLOT_DLO    = 2'd2,
        SLOT_DHI    = 2'd3
    } slot_e;

    localparam int FIXED_SLOTS = 2;

    // Decoder report as the logger sees it
    typedef struct packed {
        logic                  valid;
        logic                  sbe;
        logic                  mbe;
        logic [LOG_DATA_W-1:0] data;
        logic [LOG_CODE_W-1:0] chk;
        logic [LOG_CODE_W-1:0] syn;
    } acc_rec_t;

    function automatic logic is_fault(input logic valid, input logic sbe, input logic mbe);
        return valid && (sbe || mbe);
    endfunction

    function automatic logic is_fatal(input logic valid, input logic mbe);
        return valid && mbe;
    endfunction

endpackage

// File: rtl/ecc_err_counter.sv
module ecc_err_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic at_top;
    assign at_top = (count == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (bump && !at_top) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
    parameter int DATA_W = 64,
    parameter int SYN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fault,
    input  logic              fatal,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SYN_W-1:0]  in_syn,
    output logic              held,
    output logic              fatal_seen,
    output logic [DATA_W-1:0] held_data,
    output logic [SYN_W-1:0]  held_syn
);
    logic take;
    assign take = fault && !held;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held       <= 1'b0;
            fatal_seen <= 1'b0;
            held_data  <= '0;
            held_syn   <= '0;
        end else begin
            if (take) begin
                held      <= 1'b1;
                held_data <= in_data;
                held_syn  <= in_syn;
            end
            if (fatal) begin
                fatal_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_chk_hold.sv
module ecc_chk_hold #(
    parameter int CHK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CHK_W-1:0] in_chk,
    output logic [CHK_W-1:0] last_chk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            last_chk <= '0;
        end else if (load) begin
            last_chk <= in_chk;
        end
    end
endmodule

// File: rtl/ecc_reg_read.sv
module ecc_reg_read
    import ecc_log_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CODE_W = 8,
    parameter int CNT_W  = 4,
    parameter int RD_W   = 32,
    localparam int N_SLICE = DATA_W / RD_W,
    localparam int N_WORD  = FIXED_SLOTS + N_SLICE,
    localparam int ADDR_W  = $clog2(N_WORD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              fatal_seen,
    input  logic              held,
    input  logic [CODE_W-1:0] held_syn,
    input  logic [CODE_W-1:0] last_chk,
    input  logic [DATA_W-1:0] held_data,
    output logic [RD_W-1:0]   rd_data
);
    localparam int STAT_USED = CNT_W + 2;
    localparam int CODE_USED = 2 * CODE_W;

    logic [RD_W-1:0] words [N_WORD];

    assign words[SLOT_STATUS] = {{(RD_W-STAT_USED){1'b0}}, held, fatal_seen, count};
    assign words[SLOT_CODES]  = {{(RD_W-CODE_USED){1'b0}}, last_chk, held_syn};

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        assign words[FIXED_SLOTS+s] = held_data[s*RD_W +: RD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= words[rd_addr];
        end
    end
endmodule

// File: rtl/ecc_diag_logger.sv
module ecc_diag_logger
    import ecc_log_pkg::*;
#(
    parameter int DATA_W = LOG_DATA_W,
    parameter int CODE_W = LOG_CODE_W,
    parameter int CNT_W  = LOG_CNT_W,
    parameter int RD_W   = LOG_RD_W,
    localparam int ADDR_W = $clog2(FIXED_SLOTS + DATA_W / RD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              acc_valid,
    input  logic              acc_sbe,
    input  logic              acc_mbe,
    input  logic [DATA_W-1:0] acc_data,
    input  logic [CODE_W-1:0] acc_chk,
    input  logic [CODE_W-1:0] acc_syn,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);
    logic              fault;
    logic              fatal;
    logic [CNT_W-1:0]  count;
    logic              held;
    logic              fatal_seen;
    logic [DATA_W-1:0] held_data;
    logic [CODE_W-1:0] held_syn;
    logic [CODE_W-1:0] last_chk;

    assign fault = is_fault(acc_valid, acc_sbe, acc_mbe);
    assign fatal = is_fatal(acc_valid, acc_mbe);

    ecc_err_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .bump  (fault),
        .count (count)
    );

    ecc_err_capture #(.DATA_W(DATA_W), .SYN_W(CODE_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .fault      (fault),
        .fatal      (fatal),
        .in_data    (acc_data),
        .in_syn     (acc_syn),
        .held       (held),
        .fatal_seen (fatal_seen),
        .held_data  (held_data),
        .held_syn   (held_syn)
    );

    ecc_chk_hold #(.CHK_W(CODE_W)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .load     (acc_valid),
        .in_chk   (acc_chk),
        .last_chk (last_chk)
    );

    ecc_reg_read #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W),
        .RD_W   (RD_W)
    ) u_read (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .count      (count),
        .fatal_seen (fatal_seen),
        .held       (held),
        .held_syn   (held_syn),
        .last_chk   (last_chk),
        .held_data  (held_data),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/ecc_diag_logger_chk.sv
module ecc_diag_logger_chk #(
    parameter int DATA_W = 64,
    parameter int CODE_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              acc_valid,
    input logic              acc_sbe,
    input logic              acc_mbe,
    input logic [DATA_W-1:0] acc_data,
    input logic [CODE_W-1:0] acc_chk,
    input logic [CODE_W-1:0] acc_syn,
    input logic [CNT_W-1:0]  count,
    input logic              held,
    input logic              fatal_seen,
    input logic [DATA_W-1:0] held_data,
    input logic [CODE_W-1:0] held_syn,
    input logic [CODE_W-1:0] last_chk
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic err_in;
    assign err_in = acc_valid && (acc_sbe || acc_mbe);

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!clr && err_in && count != TOP) |=> count == $past(count) + 1'b1);

    assert_count_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!clr && !err_in) |=> $stable(count));

    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && count == TOP) |=> count == TOP);

    assert_first_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && err_in && !held) |=> held && held_data == $past(acc_data)
                                      && held_syn == $past(acc_syn));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && held) |=> $stable(held_data) && $stable(held_syn) && held);

    assert_sticky_fatal_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && (fatal_seen || (acc_valid && acc_mbe))) |=> fatal_seen);

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0 && !held && !fatal_seen && held_data == '0 && held_syn == '0);

    assert_chk_load_R7: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> last_chk == $past(acc_chk));

    assert_chk_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(last_chk));
endmodule

bind ecc_diag_logger ecc_diag_logger_chk #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
) u_logger_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .acc_valid  (acc_valid),
    .acc_sbe    (acc_sbe),
    .acc_mbe    (acc_mbe),
    .acc_data   (acc_data),
    .acc_chk    (acc_chk),
    .acc_syn    (acc_syn),
    .count      (count),
    .held       (held),
    .fatal_seen (fatal_seen),
    .held_data  (held_data),
    .held_syn   (held_syn),
    .last_chk   (last_chk)
);

// File: tb/test_ecc_diag_logger.sv
module test_ecc_diag_logger;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr;
    logic        acc_valid;
    logic        acc_sbe;
    logic        acc_mbe;
    logic [63:0] acc_data;
    logic [7:0]  acc_chk;
    logic [7:0]  acc_syn;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    // independent model of the logged state
    int          m_cnt;
    logic        m_held;
    logic        m_fatal;
    logic [63:0] m_data;
    logic [7:0]  m_syn;
    logic [7:0]  m_chk;

    always #2 clk = ~clk;

    ecc_diag_logger i_ecc_diag_logger (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .acc_valid (acc_valid),
        .acc_sbe   (acc_sbe),
        .acc_mbe   (acc_mbe),
        .acc_data  (acc_data),
        .acc_chk   (acc_chk),
        .acc_syn   (acc_syn),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_held = 0; m_fatal = 0; m_data = '0; m_syn = '0;
    endtask

    // one access cycle, optionally with clear in the same cycle
    task automatic access(input logic v, input logic s, input logic m,
                          input logic [63:0] d, input logic [7:0] c,
                          input logic [7:0] y, input logic with_clr);
        @(negedge clk);
        acc_valid = v; acc_sbe = s; acc_mbe = m;
        acc_data = d; acc_chk = c; acc_syn = y; clr = with_clr;
        @(negedge clk);
        acc_valid = 0; acc_sbe = 0; acc_mbe = 0; clr = 0;
        if (v) m_chk = c;
        if (with_clr) begin
            model_reset();
        end else if (v && (s || m)) begin
            if (m_cnt < 15) m_cnt++;
            if (!m_held) begin m_held = 1; m_data = d; m_syn = y; end
            if (m) m_fatal = 1;
        end
    endtask

    task automatic read_word(input logic [1:0] a, output logic [31:0] val);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        val = rd_data;
    endtask

    task automatic check_status(input string req);
        logic [31:0] v;
        read_word(2'd0, v);
        check(req, v, {26'b0, m_held, m_fatal, 4'(m_cnt)});
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        check_status(req);
        read_word(2'd1, v);
        check(req, v, {16'b0, m_chk, m_syn});
        read_word(2'd2, v);
        check(req, v, m_data[31:0]);
        read_word(2'd3, v);
        check(req, v, m_data[63:32]);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] hold_v;
        rst = 1; clr = 0; acc_valid = 0; acc_sbe = 0; acc_mbe = 0;
        acc_data = '0; acc_chk = '0; acc_syn = '0; rd_en = 0; rd_addr = '0;
        model_reset(); m_chk = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9 reset state, R8 all four words
        check_all("R9 reset R8 map");

        // R1 flags without valid are ignored; R7 no load without valid
        access(0, 1, 1, 64'hDEAD_BEEF_0000_1111, 8'h3C, 8'h77, 0);
        check_all("R1 invalid ignored R7");

        // R1 clean access not counted; R7 loads check bits
        access(1, 0, 0, 64'h1234_5678_9ABC_DEF0, 8'hA5, 8'h00, 0);
        check_all("R1 clean R7 load");

        // R3 first fault captured
        access(1, 1, 0, 64'hCAFE_F00D_0102_0304, 8'h5A, 8'h2B, 0);
        check_all("R3 first capture");

        // R1/R2/R4/R5 sweep of flag patterns through saturation
        for (int n = 2; n <= 18; n++) begin
            logic s, m;
            s = (n % 3) != 2;
            m = (n % 3) != 0 && n >= 6;
            access(1, s, m, {32'(n * 7919), 32'(~n)}, 8'(n * 13), 8'(n + 100), 0);
            check_all(n > 15 ? "R2 saturate R4 frozen" : "R1 count R4 frozen R5");
            // interleave an ignored pattern: valid with no flags
            access(1, 0, 0, 64'(n), 8'(n), 8'(n), 0);
            check_status("R1 no-flag access");
        end

        // R8 rd_data holds while rd_en low
        read_word(2'd2, hold_v);
        repeat (3) @(negedge clk);
        check("R8 hold", rd_data, hold_v);

        // R6 clear alone, R7 check bits kept
        access(0, 0, 0, '0, '0, '0, 1);
        check_all("R6 clear R7 kept");

        // R6 clear and fatal error in the same cycle on empty log
        access(1, 1, 1, 64'hFFFF_0000_FFFF_0000, 8'hC3, 8'h99, 1);
        check_all("R6 clear wins empty R7");

        // R3 next error after clear captured
        access(1, 0, 1, 64'h0F0F_0F0F_F0F0_F0F0, 8'h11, 8'h4D, 0);
        check_all("R3 recapture R5");

        // fill, then clear and error together on a full log
        for (int k = 0; k < 16; k++) access(1, 1, 0, 64'(k), 8'(k), 8'(k), 0);
        check_all("R2 full");
        access(1, 1, 0, 64'hAAAA_5555_AAAA_5555, 8'hE7, 8'h21, 1);
        check_all("R6 clear wins full R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule